// File: doc/BRIEF.md
# DMA Address Generation Unit

This block keeps the source and destination address pointers of one DMA channel and moves them forward after each operand is transferred. A bus sequencer requests a transfer with a start pulse. The unit then checks that the pointers suit the chosen operand size. If they do, it presents the source pointer during the read phase and the destination pointer during the write phase. When the sequencer reports that the operand is finished, or that a bus error ended it, each enabled pointer advances by the operand width.

Software reaches the two pointers and a status register through a simple register port. The port is live only while the module stop input is low. The pointers have no reset, so their contents survive a reset pulse. A transfer that is misaligned, or that uses the reserved size code, does not run. Instead it latches a configuration error, which software clears by writing a one.

Top module: `dma_addr_gen`

## Requirements
- R1: After reset the error flag and the address-valid output are 0. A reset pulse leaves the contents of both pointers unchanged.
- R2: While a transfer is active, addr_o shows the source pointer when phase_wr_i is 0 and the destination pointer when phase_wr_i is 1, and addr_vld_o is 1.
- R3: When a transfer finishes (xfer_done_i), each pointer whose increment enable was 1 at start advances by 1, 2 or 4 for size codes 00 (byte), 01 (word) and 10 (long word).
- R4: A pointer whose increment enable was 0 at start keeps its value when the transfer finishes.
- R5: Pointer arithmetic is unsigned modulo 2^32. For example, 0xFFFFFFFF plus 1 gives 0x00000000.
- R6: A start with size 01 or 10 while either pointer has bit 0 set sets the error flag on the next edge. No transfer begins, and addr_vld_o stays 0. Odd pointers are allowed for size 00.
- R7: A start with size code 11 sets the error flag and does not begin a transfer.
- R8: While the error flag is set, start requests are ignored. Writing 1 to bit 0 of the status register (select 2) clears the flag, and writing 0 there has no effect.
- R9: A bus error (bus_err_i) ends the transfer and advances the pointers exactly as a normal finish would.
- R10: A software write to a pointer in the same cycle as its increment loads the written value and drops the increment.
- R11: While stop_i is 1, register writes are ignored and reads return 0.
- R12: A read returns the current value of the selected pointer in the same cycle. Select 0 reads the source pointer, select 1 the destination pointer, and select 2 the status register with the error flag in bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| stop_i | input | 1 | Module stop; blocks register access |
| src_inc_en_i | input | 1 | Source increment enable, sampled at start |
| dst_inc_en_i | input | 1 | Destination increment enable, sampled at start |
| op_size_i | input | 2 | Operand size code, sampled at start |
| start_i | input | 1 | Transfer start request |
| phase_wr_i | input | 1 | 0 = read phase, 1 = write phase |
| xfer_done_i | input | 1 | Operand transfer completed |
| bus_err_i | input | 1 | Operand transfer ended by bus error |
| addr_o | output | 32 | Current bus address |
| addr_vld_o | output | 1 | Address valid |
| conf_err_o | output | 1 | Configuration error flag |
| reg_wr_i | input | 1 | Register write strobe |
| reg_sel_i | input | 2 | Register select |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data |

## Verification
A start or finish pulse is seen at one clock edge. The error flag, the valid output and the new pointer values are all registered, so each result is due just after that edge. Reads and the phase-selected address are combinational and are due in the same cycle as their select inputs. The bench drives every input on the falling edge, holds it across exactly one rising edge, and samples one nanosecond after the next falling edge. Each expectation therefore lands on the cycle in which its register has just updated.

// File: rtl/dma_agu_pkg.sv
package dma_agu_pkg;
  typedef enum logic [1:0] {
    SZ_BYTE = 2'b00,
    SZ_WORD = 2'b01,
    SZ_LONG = 2'b10,
    SZ_RSVD = 2'b11
  } op_size_e;

  typedef enum logic [1:0] {
    SEL_SRC  = 2'd0,
    SEL_DST  = 2'd1,
    SEL_STAT = 2'd2,
    SEL_NONE = 2'd3
  } reg_sel_e;

  localparam int STEP_W = 3;

  function automatic logic [STEP_W-1:0] step_of(logic [1:0] sz);
    case (sz)
      SZ_BYTE: step_of = 3'd1;
      SZ_WORD: step_of = 3'd2;
      SZ_LONG: step_of = 3'd4;
      default: step_of = 3'd0;
    endcase
  endfunction
endpackage

// File: rtl/dma_ptr_reg.sv
module dma_ptr_reg #(
  parameter int AW     = 32,
  parameter int STEP_W = 3
) (
  input  logic              clk_i,
  input  logic              wr_en_i,
  input  logic [AW-1:0]     wr_data_i,
  input  logic              inc_en_i,
  input  logic [STEP_W-1:0] step_i,
  output logic [AW-1:0]     ptr_o
);
  logic [AW-1:0] ptr_q;

  // no reset: contents persist across reset
  always_ff @(posedge clk_i) begin
    if (wr_en_i)       ptr_q <= wr_data_i;
    else if (inc_en_i) ptr_q <= ptr_q + AW'(step_i);
  end

  assign ptr_o = ptr_q;
endmodule

// File: rtl/dma_align_chk.sv
module dma_align_chk #(
  parameter int AW   = 32,
  parameter int NPTR = 2
) (
  input  logic [1:0]    size_i,
  input  logic [AW-1:0] ptr_i [NPTR],
  output logic          err_o
);
  logic [NPTR-1:0] odd;

  for (genvar i = 0; i < NPTR; i++) begin : g_odd
    assign odd[i] = ptr_i[i][0];
  end

  always_comb begin
    case (size_i)
      dma_agu_pkg::SZ_BYTE: err_o = 1'b0;
      dma_agu_pkg::SZ_WORD,
      dma_agu_pkg::SZ_LONG: err_o = |odd;
      default:              err_o = 1'b1;
    endcase
  end
endmodule

// File: rtl/dma_addr_gen.sv
module dma_addr_gen
  import dma_agu_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          stop_i,
  input  logic          src_inc_en_i,
  input  logic          dst_inc_en_i,
  input  logic [1:0]    op_size_i,
  input  logic          start_i,
  input  logic          phase_wr_i,
  input  logic          xfer_done_i,
  input  logic          bus_err_i,
  output logic [AW-1:0] addr_o,
  output logic          addr_vld_o,
  output logic          conf_err_o,
  input  logic          reg_wr_i,
  input  logic [1:0]    reg_sel_i,
  input  logic [AW-1:0] reg_wdata_i,
  output logic [AW-1:0] reg_rdata_o
);
  localparam int NPTR = 2;

  logic [AW-1:0]     ptr_q [NPTR];
  logic [NPTR-1:0]   inc_cfg, inc_q, ptr_wr;
  logic [1:0]        size_q;
  logic              active_q, err_q;
  logic              chk_err, start_ok, err_set, err_clr, advance;
  logic [STEP_W-1:0] step;

  assign inc_cfg  = {dst_inc_en_i, src_inc_en_i};
  assign start_ok = start_i & ~active_q & ~err_q;
  assign err_set  = start_ok & chk_err;
  assign err_clr  = reg_wr_i & ~stop_i & (reg_sel_i == SEL_STAT) & reg_wdata_i[0];
  assign advance  = active_q & (xfer_done_i | bus_err_i);
  assign step     = step_of(size_q);

  dma_align_chk #(.AW(AW), .NPTR(NPTR)) i_align (
    .size_i (op_size_i),
    .ptr_i  (ptr_q),
    .err_o  (chk_err)
  );

  for (genvar i = 0; i < NPTR; i++) begin : g_ptr
    assign ptr_wr[i] = reg_wr_i & ~stop_i & (reg_sel_i == 2'(i));
    dma_ptr_reg #(.AW(AW), .STEP_W(STEP_W)) i_ptr (
      .clk_i     (clk_i),
      .wr_en_i   (ptr_wr[i]),
      .wr_data_i (reg_wdata_i),
      .inc_en_i  (advance & inc_q[i]),
      .step_i    (step),
      .ptr_o     (ptr_q[i])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      err_q    <= 1'b0;
      size_q   <= SZ_BYTE;
      inc_q    <= '0;
    end else begin
      if (err_set)      err_q <= 1'b1;
      else if (err_clr) err_q <= 1'b0;

      if (start_ok && !chk_err) begin
        active_q <= 1'b1;
        size_q   <= op_size_i;
        inc_q    <= inc_cfg;
      end else if (advance) begin
        active_q <= 1'b0;
      end
    end
  end

  assign addr_o     = phase_wr_i ? ptr_q[1] : ptr_q[0];
  assign addr_vld_o = active_q & ~err_q;
  assign conf_err_o = err_q;

  always_comb begin
    reg_rdata_o = '0;
    if (!stop_i) begin
      case (reg_sel_i)
        SEL_SRC:  reg_rdata_o = ptr_q[0];
        SEL_DST:  reg_rdata_o = ptr_q[1];
        SEL_STAT: reg_rdata_o = {{(AW-1){1'b0}}, err_q};
        default:  reg_rdata_o = '0;
      endcase
    end
  end
endmodule

// File: rtl/dma_addr_gen_chk.sv
module dma_addr_gen_chk #(
  parameter int AW = 32
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          stop_i,
  input logic          start_i,
  input logic [1:0]    op_size_i,
  input logic          phase_wr_i,
  input logic [AW-1:0] addr_o,
  input logic          addr_vld_o,
  input logic          conf_err_o,
  input logic          reg_wr_i,
  input logic [1:0]    reg_sel_i,
  input logic [AW-1:0] reg_wdata_i,
  input logic [AW-1:0] reg_rdata_o,
  input logic          active,
  input logic          advance,
  input logic [1:0]    size_q,
  input logic [1:0]    inc_q,
  input logic [AW-1:0] src_ptr,
  input logic [AW-1:0] dst_ptr
);
  logic src_known, dst_known, src_wr, clr;
  logic [2:0] step_w;

  assign src_wr = reg_wr_i && !stop_i && reg_sel_i == 2'd0;
  assign clr    = reg_wr_i && !stop_i && reg_sel_i == 2'd2 && reg_wdata_i[0];
  assign step_w = (size_q == 2'b00) ? 3'd1 : (size_q == 2'b01) ? 3'd2 : 3'd4;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      src_known <= 1'b0;
      dst_known <= 1'b0;
    end else begin
      if (src_wr) src_known <= 1'b1;
      if (reg_wr_i && !stop_i && reg_sel_i == 2'd1) dst_known <= 1'b1;
    end
  end

  p_err_blocks_vld_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    conf_err_o |-> !addr_vld_o);
  p_rd_phase_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_vld_o && !phase_wr_i && src_known) |-> addr_o == src_ptr);
  p_wr_phase_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_vld_o && phase_wr_i && dst_known) |-> addr_o == dst_ptr);
  p_step_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (advance && inc_q[0] && src_known && !src_wr) |=>
      src_ptr == $past(src_ptr) + AW'($past(step_w)));
  p_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (advance && !inc_q[0] && src_known && !src_wr) |=> $stable(src_ptr));
  p_size_err_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !active && !conf_err_o && op_size_i == 2'b11) |=> conf_err_o);
  p_clear_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr && !start_i) |=> !conf_err_o);
  p_end_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    advance |=> !addr_vld_o);
  p_wr_prio_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    src_wr |=> src_ptr == $past(reg_wdata_i));
  p_stop_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_i |-> reg_rdata_o == '0);
endmodule

bind dma_addr_gen dma_addr_gen_chk #(.AW(AW)) i_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .stop_i      (stop_i),
  .start_i     (start_i),
  .op_size_i   (op_size_i),
  .phase_wr_i  (phase_wr_i),
  .addr_o      (addr_o),
  .addr_vld_o  (addr_vld_o),
  .conf_err_o  (conf_err_o),
  .reg_wr_i    (reg_wr_i),
  .reg_sel_i   (reg_sel_i),
  .reg_wdata_i (reg_wdata_i),
  .reg_rdata_o (reg_rdata_o),
  .active      (active_q),
  .advance     (advance),
  .size_q      (size_q),
  .inc_q       (inc_q),
  .src_ptr     (ptr_q[0]),
  .dst_ptr     (ptr_q[1])
);

// File: tb/test_dma_addr_gen.sv
module test_dma_addr_gen;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        stop_i = 1'b0, src_inc = 1'b0, dst_inc = 1'b0;
  logic [1:0]  op_size = 2'b00;
  logic        start = 1'b0, phase_wr = 1'b0, xfer_done = 1'b0, bus_err = 1'b0;
  logic [31:0] addr;
  logic        addr_vld, conf_err;
  logic        reg_wr = 1'b0;
  logic [1:0]  reg_sel = 2'd0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  int n_run = 0, n_fail = 0;

  always #4 clk = ~clk;

  dma_addr_gen i_dma_addr_gen (
    .clk_i(clk), .rst_ni(rst_ni), .stop_i(stop_i),
    .src_inc_en_i(src_inc), .dst_inc_en_i(dst_inc), .op_size_i(op_size),
    .start_i(start), .phase_wr_i(phase_wr), .xfer_done_i(xfer_done),
    .bus_err_i(bus_err), .addr_o(addr), .addr_vld_o(addr_vld),
    .conf_err_o(conf_err), .reg_wr_i(reg_wr), .reg_sel_i(reg_sel),
    .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic reg_write(logic [1:0] sel, logic [31:0] data);
    @(negedge clk);
    reg_wr = 1'b1; reg_sel = sel; reg_wdata = data;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic reg_read(logic [1:0] sel, output logic [31:0] data);
    reg_sel = sel;
    #1 data = reg_rdata;
  endtask

  task automatic set_ptrs(logic [31:0] s, logic [31:0] d);
    reg_write(2'd0, s);
    reg_write(2'd1, d);
  endtask

  task automatic start_xfer(logic [1:0] sz, logic si, logic di);
    @(negedge clk);
    op_size = sz; src_inc = si; dst_inc = di; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    #1;
  endtask

  task automatic finish_xfer(logic err);
    @(negedge clk);
    if (err) bus_err = 1'b1; else xfer_done = 1'b1;
    @(negedge clk);
    bus_err = 1'b0; xfer_done = 1'b0;
    #1;
  endtask

  task automatic expect_ptrs(string req, logic [31:0] s, logic [31:0] d);
    logic [31:0] v;
    reg_read(2'd0, v); chk({req, " src"}, v, s);
    reg_read(2'd1, v); chk({req, " dst"}, v, d);
  endtask

  task automatic t_reset;
    logic [31:0] v;
    chk("R1 err after reset", {31'd0, conf_err}, 32'd0);
    chk("R1 vld after reset", {31'd0, addr_vld}, 32'd0);
    reg_write(2'd0, 32'hA5A5_0000);
    @(negedge clk); rst_ni = 1'b0;
    @(negedge clk); rst_ni = 1'b1;
    reg_read(2'd0, v);
    chk("R1 pointer kept over reset", v, 32'hA5A5_0000);
  endtask

  task automatic t_phase;
    set_ptrs(32'h0000_1000, 32'h0000_2000);
    start_xfer(2'b00, 1'b1, 1'b1);
    chk("R2 vld", {31'd0, addr_vld}, 32'd1);
    phase_wr = 1'b0; #1 chk("R2 read addr", addr, 32'h0000_1000);
    phase_wr = 1'b1; #1 chk("R2 write addr", addr, 32'h0000_2000);
    phase_wr = 1'b0;
    finish_xfer(1'b0);
    expect_ptrs("R3 byte R12", 32'h0000_1001, 32'h0000_2001);
  endtask

  task automatic t_step;
    set_ptrs(32'h100, 32'h200);
    start_xfer(2'b01, 1'b1, 1'b1); finish_xfer(1'b0);
    expect_ptrs("R3 word", 32'h102, 32'h202);
    start_xfer(2'b10, 1'b1, 1'b1); finish_xfer(1'b0);
    expect_ptrs("R3 long", 32'h106, 32'h206);
  endtask

  task automatic t_hold;
    set_ptrs(32'h300, 32'h400);
    start_xfer(2'b01, 1'b0, 1'b1); finish_xfer(1'b0);
    expect_ptrs("R4 src held", 32'h300, 32'h402);
    start_xfer(2'b01, 1'b1, 1'b0); finish_xfer(1'b0);
    expect_ptrs("R4 dst held", 32'h302, 32'h402);
  endtask

  task automatic t_wrap;
    set_ptrs(32'hFFFF_FFFF, 32'h0000_0000);
    start_xfer(2'b00, 1'b1, 1'b0); finish_xfer(1'b0);
    expect_ptrs("R5 byte wrap", 32'h0, 32'h0);
    set_ptrs(32'hFFFF_FFFC, 32'hFFFF_FFFE);
    start_xfer(2'b10, 1'b1, 1'b1); finish_xfer(1'b0);
    expect_ptrs("R5 long wrap", 32'h0, 32'h2);
  endtask

  task automatic t_misalign;
    logic [31:0] v;
    set_ptrs(32'h1001, 32'h2000);
    start_xfer(2'b01, 1'b1, 1'b1);
    chk("R6 err odd src word", {31'd0, conf_err}, 32'd1);
    chk("R6 no vld", {31'd0, addr_vld}, 32'd0);
    reg_read(2'd2, v); chk("R6 R12 status read", v, 32'd1);
    reg_write(2'd2, 32'd1);
    start_xfer(2'b00, 1'b1, 1'b1);
    chk("R6 odd byte ok", {31'd0, conf_err}, 32'd0);
    chk("R6 odd byte vld", {31'd0, addr_vld}, 32'd1);
    finish_xfer(1'b0);
    expect_ptrs("R6 odd byte step", 32'h1002, 32'h2001);
    set_ptrs(32'h10, 32'h21);
    start_xfer(2'b10, 1'b1, 1'b1);
    chk("R6 err odd dst long", {31'd0, conf_err}, 32'd1);
    chk("R6 no vld long", {31'd0, addr_vld}, 32'd0);
    reg_write(2'd2, 32'd1);
    expect_ptrs("R6 ptrs untouched", 32'h10, 32'h21);
  endtask

  task automatic t_size11;
    set_ptrs(32'h40, 32'h80);
    start_xfer(2'b11, 1'b1, 1'b1);
    chk("R7 err rsvd size", {31'd0, conf_err}, 32'd1);
    chk("R7 no vld", {31'd0, addr_vld}, 32'd0);
  endtask

  task automatic t_clear;
    start_xfer(2'b00, 1'b1, 1'b1);
    chk("R8 start ignored vld", {31'd0, addr_vld}, 32'd0);
    chk("R8 err held", {31'd0, conf_err}, 32'd1);
    reg_write(2'd2, 32'd0);
    chk("R8 write 0 no clear", {31'd0, conf_err}, 32'd1);
    reg_write(2'd2, 32'd1);
    chk("R8 write 1 clears", {31'd0, conf_err}, 32'd0);
    start_xfer(2'b00, 1'b1, 1'b1);
    chk("R8 start after clear", {31'd0, addr_vld}, 32'd1);
    finish_xfer(1'b0);
  endtask

  task automatic t_buserr;
    set_ptrs(32'h500, 32'h600);
    start_xfer(2'b10, 1'b1, 1'b1);
    finish_xfer(1'b1);
    chk("R9 ended", {31'd0, addr_vld}, 32'd0);
    expect_ptrs("R9 advanced", 32'h504, 32'h604);
  endtask

  task automatic t_prio;
    set_ptrs(32'h700, 32'h800);
    start_xfer(2'b01, 1'b1, 1'b1);
    @(negedge clk);
    xfer_done = 1'b1; reg_wr = 1'b1; reg_sel = 2'd0; reg_wdata = 32'h1234_5678;
    @(negedge clk);
    xfer_done = 1'b0; reg_wr = 1'b0;
    expect_ptrs("R10 write wins", 32'h1234_5678, 32'h802);
  endtask

  task automatic t_stop;
    logic [31:0] v;
    reg_write(2'd0, 32'h900);
    @(negedge clk); stop_i = 1'b1;
    reg_read(2'd0, v); chk("R11 read while stopped", v, 32'h0);
    reg_write(2'd0, 32'hDEAD);
    @(negedge clk); stop_i = 1'b0;
    reg_read(2'd0, v); chk("R11 write ignored", v, 32'h900);
  endtask

  initial begin
    repeat (2) @(negedge clk);
    rst_ni = 1'b1;
    #1;
    t_reset();
    t_phase();
    t_step();
    t_hold();
    t_wrap();
    t_misalign();
    t_size11();
    t_clear();
    t_buserr();
    t_prio();
    t_stop();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #(8 * 200000);
    n_run++; n_fail++;
    $display("FAIL watchdog actual=running expected=done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule